// File: doc/BRIEF.md
# Processor Bus Command Decoder

This block sits beside a processor that runs in its maximum-configuration mode, where the processor does not drive the bus commands itself. The processor reports each bus cycle on three status lines. The block samples those lines on the bus clock and produces four things: an address latch strobe, a transfer direction, a data buffer enable, and one command strobe for the cycle type. The command strobes cover memory read, memory write, I/O read, I/O write and interrupt acknowledge. Both kinds of write also have an early ("advanced") strobe. Outputs are active high.

A cycle-phase state machine runs the timing. It has four states:
- IDLE: no bus cycle is in progress.
- ADDR: the address phase, one clock long.
- CMD: the first command clock.
- HOLD: the remaining command clocks, until the status returns to passive.

The transitions are:
- IDLE→ADDR when a non-passive status is sampled. The decoded cycle kind is stored at this point.
- ADDR→CMD always.
- CMD→IDLE or HOLD→IDLE when a passive status is sampled.
- CMD→HOLD when a non-passive status is sampled.
- HOLD→HOLD when a non-passive status is sampled.

A command-enable input and an arbiter address-enable input gate the command strobes, so that several bus masters can share one bus. An I/O bus mode input changes which commands the arbiter can block. In the same mode, the interrupt-cascade output becomes a peripheral data enable.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, every output is low. After reset the block is idle.
- R2: A non-passive status sampled while idle starts a cycle. `ale` is then high for exactly the next clock, and this holds for every kind, halt included.
- R3: The status encoding is 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write and 111 passive. During the command clocks (CMD and HOLD), the cycle drives:
  - `int_ack` for 000;
  - `io_rd` for 001;
  - `mem_rd` for both 100 and 101.
  A halt cycle drives no command strobe.
- R4: Starting with the first command clock, write cycles (110 and 010) assert `mem_wr_adv` or `io_wr_adv`. The matching normal strobe, `mem_wr` or `io_wr`, asserts one clock later.
- R5: When a passive status is sampled in CMD or HOLD, every strobe and enable drops on that edge.
- R6: `dt_tx` is high from the address clock to the end of the cycle for write kinds (010 and 110). It is low for every other kind.
- R7: `data_en` is high during the command clocks of every kind except halt.
- R8: While `cmd_en` is low, all seven command strobes are low. ALE, direction and data enable are not affected.
- R9: When `addr_en` is low and `io_bus_mode` is 0, the memory strobes (`mem_rd`, `mem_wr`, `mem_wr_adv`) are low, while I/O and interrupt strobes still follow. When `io_bus_mode` is 1, `addr_en` has no effect.
- R10: The behaviour of `cas_pden` depends on `io_bus_mode`:
  - With `io_bus_mode`=0, it is high for the whole of an interrupt acknowledge cycle (ADDR to end).
  - With `io_bus_mode`=1, it is high during the command clocks of I/O read, I/O write and interrupt acknowledge cycles.
- R11: The cycle kind is fixed when the cycle starts. Status changes between non-passive codes later in the same cycle do not change which strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_status | input | 3 | Processor status code (111 = passive) |
| cmd_en | input | 1 | Command enable; low blocks every command strobe |
| addr_en | input | 1 | Arbiter grant; low blocks memory strobes when not in I/O bus mode |
| io_bus_mode | input | 1 | Selects I/O bus gating and the peripheral data enable role |
| ale | output | 1 | Address latch strobe, one clock per cycle |
| dt_tx | output | 1 | Data direction: 1 transmit (write), 0 receive |
| data_en | output | 1 | Data buffer enable |
| cas_pden | output | 1 | Interrupt cascade enable, or peripheral data enable in I/O bus mode |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| mem_wr_adv | output | 1 | Advanced memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| io_wr_adv | output | 1 | Advanced I/O write command |
| int_ack | output | 1 | Interrupt acknowledge command |

## Verification
A wrong phase state shows up at once at the ports:
- a missing or doubled `ale` pulse;
- a normal write strobe arriving together with its advanced strobe instead of one clock later;
- strobes that stay high on the clock after passive is sampled.

A corrupted stored kind shows up as the wrong strobe from the first command clock, and as a `dt_tx` of the wrong polarity from the address clock. The bench compares all eleven outputs on every clock against a model built from the requirements, so any such error is reported in the cycle it first appears. The random stimulus also toggles the gating inputs in the middle of cycles.

// File: rtl/bcc_pkg.sv
`timescale 1ns/1ps
package bcc_pkg;

    localparam int STAT_W = 3;

    // Status codes driven by the processor
    localparam logic [STAT_W-1:0] S_INTA    = 3'b000;
    localparam logic [STAT_W-1:0] S_IORD    = 3'b001;
    localparam logic [STAT_W-1:0] S_IOWR    = 3'b010;
    localparam logic [STAT_W-1:0] S_HALT    = 3'b011;
    localparam logic [STAT_W-1:0] S_FETCH   = 3'b100;
    localparam logic [STAT_W-1:0] S_MRD     = 3'b101;
    localparam logic [STAT_W-1:0] S_MWR     = 3'b110;
    localparam logic [STAT_W-1:0] S_PASSIVE = 3'b111;

    typedef enum logic [2:0] {
        K_INTA,
        K_IORD,
        K_IOWR,
        K_HALT,
        K_MRD,
        K_MWR
    } kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic mrd;
        logic mwr;
        logic mwr_adv;
        logic iord;
        logic iowr;
        logic iowr_adv;
        logic inta;
    } cmd_t;

endpackage

// File: rtl/bcc_decode.sv
`timescale 1ns/1ps
module bcc_decode
    import bcc_pkg::*;
(
    input  logic [STAT_W-1:0] stat_i,
    output kind_e             kind_o,
    output logic              active_o
);

    always_comb begin
        kind_o   = K_HALT;
        active_o = 1'b1;
        unique case (stat_i)
            S_INTA:    kind_o = K_INTA;
            S_IORD:    kind_o = K_IORD;
            S_IOWR:    kind_o = K_IOWR;
            S_HALT:    kind_o = K_HALT;
            S_FETCH:   kind_o = K_MRD;
            S_MRD:     kind_o = K_MRD;
            S_MWR:     kind_o = K_MWR;
            S_PASSIVE: begin
                kind_o   = K_HALT;
                active_o = 1'b0;
            end
            default: begin
                kind_o   = K_HALT;
                active_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bcc_fsm.sv
`timescale 1ns/1ps
module bcc_fsm
    import bcc_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  active_i,
    input  kind_e kind_i,
    output logic  ale_o,
    output logic  dt_o,
    output logic  den_o,
    output logic  cas_win_o,
    output logic  pden_win_o,
    output cmd_t  raw_o
);

    phase_e phase_q, phase_d;
    kind_e  kind_q,  kind_d;

    // Next-state selection
    always_comb begin
        phase_d = phase_q;
        kind_d  = kind_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (active_i) begin
                    phase_d = PH_ADDR;
                    kind_d  = kind_i;
                end
            end
            PH_ADDR: phase_d = PH_CMD;
            PH_CMD:  phase_d = active_i ? PH_HOLD : PH_IDLE;
            PH_HOLD: phase_d = active_i ? PH_HOLD : PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= PH_IDLE;
            kind_q  <= K_HALT;
        end else begin
            phase_q <= phase_d;
            kind_q  <= kind_d;
        end
    end

    // Output decode from phase and stored kind
    logic busy, cmd_ph, hold_ph, is_wr;

    always_comb begin
        busy    = 1'b0;
        cmd_ph  = 1'b0;
        hold_ph = 1'b0;
        unique case (phase_q)
            PH_IDLE: busy = 1'b0;
            PH_ADDR: busy = 1'b1;
            PH_CMD: begin
                busy   = 1'b1;
                cmd_ph = 1'b1;
            end
            PH_HOLD: begin
                busy    = 1'b1;
                cmd_ph  = 1'b1;
                hold_ph = 1'b1;
            end
            default: busy = 1'b0;
        endcase

        is_wr = (kind_q == K_MWR) || (kind_q == K_IOWR);

        ale_o      = (phase_q == PH_ADDR);
        dt_o       = busy && is_wr;
        den_o      = cmd_ph && (kind_q != K_HALT);
        cas_win_o  = busy && (kind_q == K_INTA);
        pden_win_o = cmd_ph && ((kind_q == K_INTA) || (kind_q == K_IORD) ||
                                (kind_q == K_IOWR));

        raw_o.mrd      = cmd_ph  && (kind_q == K_MRD);
        raw_o.mwr_adv  = cmd_ph  && (kind_q == K_MWR);
        raw_o.mwr      = hold_ph && (kind_q == K_MWR);
        raw_o.iord     = cmd_ph  && (kind_q == K_IORD);
        raw_o.iowr_adv = cmd_ph  && (kind_q == K_IOWR);
        raw_o.iowr     = hold_ph && (kind_q == K_IOWR);
        raw_o.inta     = cmd_ph  && (kind_q == K_INTA);
    end

    // R2
    ale_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ale_o |=> !ale_o);

    // R5
    passive_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((phase_q == PH_CMD || phase_q == PH_HOLD) && !active_i) |=> (phase_q == PH_IDLE));

    // R11
    kind_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q != PH_IDLE) |=> (phase_q == PH_IDLE || $stable(kind_q)));

endmodule

// File: rtl/bcc_gate.sv
`timescale 1ns/1ps
module bcc_gate
    import bcc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  cmd_t raw_i,
    input  logic cas_win_i,
    input  logic pden_win_i,
    input  logic cmd_en_i,
    input  logic addr_en_i,
    input  logic iob_i,
    output cmd_t cmd_o,
    output logic cas_pden_o
);

    logic mem_ok, io_ok;

    always_comb begin
        io_ok  = cmd_en_i;
        mem_ok = cmd_en_i && (addr_en_i || iob_i);

        cmd_o.mrd      = raw_i.mrd      && mem_ok;
        cmd_o.mwr      = raw_i.mwr      && mem_ok;
        cmd_o.mwr_adv  = raw_i.mwr_adv  && mem_ok;
        cmd_o.iord     = raw_i.iord     && io_ok;
        cmd_o.iowr     = raw_i.iowr     && io_ok;
        cmd_o.iowr_adv = raw_i.iowr_adv && io_ok;
        cmd_o.inta     = raw_i.inta     && io_ok;

        cas_pden_o = iob_i ? pden_win_i : cas_win_i;
    end

    // R3
    one_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({cmd_o.mrd, cmd_o.mwr_adv, cmd_o.iord, cmd_o.iowr_adv, cmd_o.inta}));

    // R4
    mwr_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        raw_i.mwr |-> $past(raw_i.mwr_adv));

    // R4
    iowr_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        raw_i.iowr |-> $past(raw_i.iowr_adv));

endmodule

// File: rtl/bus_cmd_ctrl.sv
`timescale 1ns/1ps
module bus_cmd_ctrl
    import bcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] bus_status,
    input  logic              cmd_en,
    input  logic              addr_en,
    input  logic              io_bus_mode,
    output logic              ale,
    output logic              dt_tx,
    output logic              data_en,
    output logic              cas_pden,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_wr_adv,
    output logic              io_rd,
    output logic              io_wr,
    output logic              io_wr_adv,
    output logic              int_ack
);

    kind_e dec_kind;
    logic  dec_active;
    logic  cas_win, pden_win;
    cmd_t  raw_cmd, out_cmd;

    bcc_decode u_dec (
        .stat_i   (bus_status),
        .kind_o   (dec_kind),
        .active_o (dec_active)
    );

    bcc_fsm u_fsm (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .active_i   (dec_active),
        .kind_i     (dec_kind),
        .ale_o      (ale),
        .dt_o       (dt_tx),
        .den_o      (data_en),
        .cas_win_o  (cas_win),
        .pden_win_o (pden_win),
        .raw_o      (raw_cmd)
    );

    bcc_gate u_gate (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .raw_i      (raw_cmd),
        .cas_win_i  (cas_win),
        .pden_win_i (pden_win),
        .cmd_en_i   (cmd_en),
        .addr_en_i  (addr_en),
        .iob_i      (io_bus_mode),
        .cmd_o      (out_cmd),
        .cas_pden_o (cas_pden)
    );

    assign mem_rd     = out_cmd.mrd;
    assign mem_wr     = out_cmd.mwr;
    assign mem_wr_adv = out_cmd.mwr_adv;
    assign io_rd      = out_cmd.iord;
    assign io_wr      = out_cmd.iowr;
    assign io_wr_adv  = out_cmd.iowr_adv;
    assign int_ack    = out_cmd.inta;

    // R8
    cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_en |-> !(mem_rd || mem_wr || mem_wr_adv || io_rd || io_wr || io_wr_adv || int_ack));

    // R6
    dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && $past(data_en)) |-> $stable(dt_tx));

endmodule

// File: tb/bus_cmd_ctrl_test.sv
`timescale 1ns/1ps
module bus_cmd_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] bus_status = 3'b111;
    logic cmd_en = 1'b1, addr_en = 1'b1, io_bus_mode = 1'b0;
    logic ale, dt_tx, data_en, cas_pden, mem_rd, mem_wr, mem_wr_adv;
    logic io_rd, io_wr, io_wr_adv, int_ack;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_cmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_status(bus_status), .cmd_en(cmd_en),
        .addr_en(addr_en), .io_bus_mode(io_bus_mode), .ale(ale), .dt_tx(dt_tx),
        .data_en(data_en), .cas_pden(cas_pden), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wr_adv(mem_wr_adv), .io_rd(io_rd), .io_wr(io_wr),
        .io_wr_adv(io_wr_adv), .int_ack(int_ack)
    );

    // Reference model of cycle progress, built from the requirements
    logic       m_busy;
    int         m_ph;
    logic [2:0] m_k;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_ph <= 0; m_k <= 3'b111;
        end else if (!m_busy) begin
            if (bus_status != 3'b111) begin
                m_busy <= 1'b1; m_ph <= 1; m_k <= bus_status;
            end
        end else if (m_ph == 1) begin
            m_ph <= 2;
        end else if (bus_status == 3'b111) begin
            m_busy <= 1'b0; m_ph <= 0;
        end else begin
            m_ph <= 3;
        end
    end

    // Bit order: ale dt den cas mrd mwr mwra iord iowr iowra inta
    function automatic logic [10:0] expect_out(logic busy, int ph, logic [2:0] k,
                                               logic ce, logic ae, logic iob);
        logic cmdp, hold, mok, wrk;
        logic [10:0] e;
        cmdp = busy && (ph >= 2);
        hold = busy && (ph == 3);
        mok  = ce && (ae || iob);
        wrk  = (k == 3'b010) || (k == 3'b110);
        e[10] = busy && (ph == 1);
        e[9]  = busy && wrk;
        e[8]  = cmdp && (k != 3'b011);
        e[7]  = iob ? (cmdp && (k == 3'b000 || k == 3'b001 || k == 3'b010))
                    : (busy && k == 3'b000);
        e[6]  = cmdp && (k == 3'b100 || k == 3'b101) && mok;
        e[5]  = hold && (k == 3'b110) && mok;
        e[4]  = cmdp && (k == 3'b110) && mok;
        e[3]  = cmdp && (k == 3'b001) && ce;
        e[2]  = hold && (k == 3'b010) && ce;
        e[1]  = cmdp && (k == 3'b010) && ce;
        e[0]  = cmdp && (k == 3'b000) && ce;
        return e;
    endfunction

    function automatic string req_of(int i);
        case (i)
            10: return "R2 ale";
            9:  return "R6 dt_tx";
            8:  return "R7 data_en";
            7:  return "R10 cas_pden";
            6:  return "R3 mem_rd";
            5:  return "R4 mem_wr";
            4:  return "R4 mem_wr_adv";
            3:  return "R3 io_rd";
            2:  return "R4 io_wr";
            1:  return "R4 io_wr_adv";
            default: return "R3 int_ack";
        endcase
    endfunction

    task automatic compare(string tag);
        logic [10:0] act, exp;
        act = {ale, dt_tx, data_en, cas_pden, mem_rd, mem_wr, mem_wr_adv,
               io_rd, io_wr, io_wr_adv, int_ack};
        exp = expect_out(m_busy, m_ph, m_k, cmd_en, addr_en, io_bus_mode);
        for (int i = 0; i < 11; i++) begin
            n_chk++;
            if (act[i] !== exp[i]) begin
                n_bad++;
                $display("FAIL %s %s: got %b expected %b at %0t",
                         req_of(i), tag, act[i], exp[i], $time);
            end
        end
    endtask

    // One clock: check outputs at the falling edge, then drive the next inputs
    task automatic cyc(logic [2:0] s, logic ce, logic ae, logic iob, string tag);
        @(negedge clk);
        compare(tag);
        bus_status = s; cmd_en = ce; addr_en = ae; io_bus_mode = iob;
    endtask

    task automatic bus_cycle(logic [2:0] s, int len, logic ce, logic ae,
                             logic iob, string tag);
        for (int i = 0; i < len; i++) cyc(s, ce, ae, iob, tag);
        cyc(3'b111, ce, ae, iob, tag);
        cyc(3'b111, ce, ae, iob, tag);
        cyc(3'b111, ce, ae, iob, tag);
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h00C0FFEE);
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        cyc(3'b111, 1, 1, 0, "R1 idle");

        bus_cycle(3'b110, 4, 1, 1, 0, "R4 R5 mem write");
        bus_cycle(3'b010, 3, 1, 1, 0, "R4 R6 io write");
        bus_cycle(3'b001, 3, 1, 1, 0, "R3 io read");
        bus_cycle(3'b100, 3, 1, 1, 0, "R3 fetch");
        bus_cycle(3'b101, 1, 1, 1, 0, "R5 short read");
        bus_cycle(3'b011, 3, 1, 1, 0, "R2 R7 halt");
        bus_cycle(3'b000, 3, 1, 1, 0, "R10 inta cascade");
        bus_cycle(3'b000, 3, 1, 1, 1, "R10 inta pden");
        bus_cycle(3'b001, 3, 1, 1, 1, "R10 io pden");
        bus_cycle(3'b101, 3, 0, 1, 0, "R8 cmd off");
        bus_cycle(3'b110, 3, 1, 0, 0, "R9 mem blocked");
        bus_cycle(3'b001, 3, 1, 0, 0, "R9 io passes");
        bus_cycle(3'b101, 3, 1, 0, 1, "R9 iob ignores addr_en");
        cyc(3'b101, 1, 1, 0, "R11 start");
        cyc(3'b010, 1, 1, 0, "R11 change");
        cyc(3'b000, 1, 1, 0, "R11 change");
        bus_cycle(3'b000, 1, 1, 1, 0, "R11 hold kind");

        for (int n = 0; n < 3000; n++) begin
            logic [2:0] s;
            s = ($urandom % 3 == 0) ? 3'b111 : 3'($urandom % 8);
            cyc(s, ($urandom % 5) != 0, ($urandom % 4) != 0, ($urandom % 3) == 0,
                "random");
        end
        cyc(3'b111, 1, 1, 0, "final");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule